// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block decides where instruction fetch goes next in a pipeline whose branches and jumps carry exactly one delay slot. On each cycle with a valid instruction it takes the decoded control-transfer kind, the two 64-bit operands, the 16-bit branch offset or the 26-bit jump index, and an idle-loop hint. From these it produces the address of the next instruction. The branch condition and the target are fixed when the branch issues, so the delay-slot instruction can overwrite the operands without changing the branch outcome. The slot then retires and the PC moves to the target or falls through.

There are two forms of conditional branch. In the normal form the slot always runs. In the likely form a branch that is not taken squashes the slot: the PC steps over it and a one-cycle nullify pulse reports the skip. A jump-and-link produces a one-cycle link-register write, sign-extended to 64 bits, when its slot retires. A cycle counter is updated each time a transfer resolves, by half the byte distance fetch has covered since the previous update. A branch that loops on itself while the caller is only waiting for a compare event can make the counter jump forward instead of spinning.

Top module: `nxpc_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pc` equals the `BOOT_PC` parameter, `cycle_cnt` is zero, and `in_slot`, `slot_nullify`, `link_we` and `slot_err` are low.
- R2: A valid instruction that is not a transfer moves `pc` up by 4 at the next edge. A cycle with `ins_valid` low leaves `pc`, `cycle_cnt` and `in_slot` unchanged.
- R3: An issued normal branch or jump always moves `pc` to its own address + 4 and raises `in_slot` for the slot instruction. The condition is taken from the operands seen at issue, so operand values during the slot do not affect the outcome.
- R4: When its delay slot retires, a taken conditional branch sets `pc` to branch address + 4 + (sign-extended `br_off`) × 4. A branch that is not taken sets `pc` to branch address + 8.
- R5: `br_kind` encoding: 0 none, 1 equal, 2 not-equal, 3 less-or-equal-zero, 4 greater-than-zero, 5 to 8 the likely forms of 1 to 4 in the same order, 9 jump, 10 jump-and-link, 11 to 15 none. Equality compares all 64 bits of `op_a` and `op_b`. The two zero tests read `op_a` as a signed 64-bit value.
- R6: A likely branch whose condition fails moves `pc` to branch address + 8 with `in_slot` low, and `slot_nullify` is high for the next cycle only. A likely branch that is taken behaves like a normal taken branch.
- R7: The target of a jump is bits [31:28] of the slot address followed by `jmp_idx` and two zero bits.
- R8: In the cycle after a jump-and-link's slot retires, `link_we` is high for one cycle and `link_data` holds the slot address + 4, sign-extended from bit 31 to 64 bits.
- R9: When a transfer resolves (its slot retires or a likely branch drops its slot), `cycle_cnt` grows by (branch address + 8 − mark) / 2, where the mark is the resolved address of the previous update, starting at `BOOT_PC`. The mark then becomes the new `pc`.
- R10: An issued branch whose condition holds, with `idle_loop` high and a signed `cmp_gap` greater than 3, does not move `pc` and opens no slot. Instead `cycle_cnt` grows by (branch address − mark) / 2 plus `cmp_gap` with its two low bits cleared, and the mark becomes the branch address. With `cmp_gap` of 3 or less the branch runs normally.
- R11: A transfer kind decoded in the delay slot is not executed. `slot_err` is high for one cycle after that slot retires, and `pc` follows the outcome of the first branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | The instruction at `pc` is issued this cycle |
| br_kind | input | 4 | Decoded transfer kind (R5 encoding) |
| idle_loop | input | 1 | The branch targets its own address (idle-wait loop) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| br_off | input | 16 | Branch word offset |
| jmp_idx | input | 26 | Jump word index |
| cmp_gap | input | 32 | Signed counter distance to the next compare event |
| pc | output | 32 | Address of the instruction being presented |
| in_slot | output | 1 | Current instruction is a delay slot |
| slot_nullify | output | 1 | The previous likely branch dropped its slot |
| link_we | output | 1 | Link register write strobe |
| link_data | output | 64 | Link register write value |
| slot_err | output | 1 | A transfer was found in a delay slot |
| cycle_cnt | output | CNT_W | Cycle counter |

## Verification
On every cycle the assertions check the following: `pc` stays word aligned; stalls freeze `pc` and the counter; a slot lasts exactly one valid cycle; a nullify pulse matches an 8-byte step with no link write; a link value is the retired slot address + 4 with its upper half copying bit 31; a slot error only follows a slot; an idle skip keeps `pc` and opens no slot. Only the bench scenarios can show the values that depend on the branch kind. These are the signed and full-width conditions, the negative offsets, the jump region, the taken and dropped outcomes of likely branches, the counter amounts at each resolution and skip, and the operand capture across the slot.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  localparam int PC_W     = 32;
  localparam int DATA_W   = 64;
  localparam int OFF_W    = 16;
  localparam int IDX_W    = 26;
  localparam int REGION_W = PC_W - IDX_W - 2;
  localparam int GAP_W    = 32;
  localparam int INSN_B   = 4;

  typedef enum logic [3:0] {
    BK_NONE  = 4'd0,
    BK_EQ    = 4'd1,
    BK_NE    = 4'd2,
    BK_LEZ   = 4'd3,
    BK_GTZ   = 4'd4,
    BK_EQ_L  = 4'd5,
    BK_NE_L  = 4'd6,
    BK_LEZ_L = 4'd7,
    BK_GTZ_L = 4'd8,
    BK_JMP   = 4'd9,
    BK_JAL   = 4'd10
  } br_kind_e;

  // branch target relative to the slot address
  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] slot_pc,
                                                 input logic [OFF_W-1:0] off);
    logic [PC_W-1:0] disp;
    disp = {{(PC_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return slot_pc + disp;
  endfunction

  // jump target: region bits of the slot address kept
  function automatic logic [PC_W-1:0] region_target(input logic [PC_W-1:0] slot_pc,
                                                    input logic [IDX_W-1:0] idx);
    return {slot_pc[PC_W-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] sext_link(input logic [PC_W-1:0] v);
    return {{(DATA_W-PC_W){v[PC_W-1]}}, v};
  endfunction

  function automatic logic [PC_W-1:0] half_dist(input logic [PC_W-1:0] to_pc,
                                                input logic [PC_W-1:0] from_pc);
    logic [PC_W-1:0] d;
    d = to_pc - from_pc;
    return d >> 1;
  endfunction

  function automatic logic [GAP_W-1:0] skip_amount(input logic [GAP_W-1:0] gap);
    return gap & {{(GAP_W-2){1'b1}}, 2'b00};
  endfunction

  function automatic logic gap_exceeds(input logic [GAP_W-1:0] gap, input int min_gap);
    return $signed(gap) > $signed(GAP_W'(min_gap));
  endfunction

  function automatic logic cond_eval(input br_kind_e k,
                                     input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    logic r;
    case (k)
      BK_EQ, BK_EQ_L:   r = (a == b);
      BK_NE, BK_NE_L:   r = (a != b);
      BK_LEZ, BK_LEZ_L: r = ($signed(a) <= 0);
      BK_GTZ, BK_GTZ_L: r = ($signed(a) > 0);
      BK_JMP, BK_JAL:   r = 1'b1;
      default:          r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nxpc_cond.sv
module nxpc_cond
  import nxpc_pkg::*;
(
  input  logic [3:0]        kind_raw,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              is_xfer,
  output logic              is_likely,
  output logic              is_jump,
  output logic              is_link,
  output logic              taken
);

  br_kind_e k;

  always_comb begin
    k         = br_kind_e'(kind_raw);
    is_xfer   = 1'b0;
    is_likely = 1'b0;
    is_jump   = 1'b0;
    is_link   = 1'b0;
    case (k)
      BK_EQ, BK_NE, BK_LEZ, BK_GTZ:         is_xfer = 1'b1;
      BK_EQ_L, BK_NE_L, BK_LEZ_L, BK_GTZ_L: begin
        is_xfer   = 1'b1;
        is_likely = 1'b1;
      end
      BK_JMP: begin
        is_xfer = 1'b1;
        is_jump = 1'b1;
      end
      BK_JAL: begin
        is_xfer = 1'b1;
        is_jump = 1'b1;
        is_link = 1'b1;
      end
      default: ;
    endcase
    taken = is_xfer & cond_eval(k, opa, opb);
  end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
  import nxpc_pkg::*;
(
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             is_jump,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  output logic [PC_W-1:0]  slot_pc,
  output logic [PC_W-1:0]  tgt
);

  always_comb begin
    slot_pc = cur_pc + PC_W'(INSN_B);
    tgt     = is_jump ? region_target(slot_pc, idx) : rel_target(slot_pc, off);
  end

endmodule

// File: rtl/nxpc_count.sv
module nxpc_count
  import nxpc_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter logic [PC_W-1:0] MARK_INIT = '0,
  parameter bit              IDLE_SKIP = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [PC_W-1:0]  adv_to,
  input  logic [PC_W-1:0]  new_mark,
  input  logic             skip_en,
  input  logic [GAP_W-1:0] skip_amt,
  output logic [CNT_W-1:0] cnt
);

  logic [PC_W-1:0]  mark_q;
  logic [CNT_W-1:0] step_dist;
  logic [CNT_W-1:0] step_skip;

  assign step_dist = CNT_W'(half_dist(adv_to, mark_q));

  generate
    if (IDLE_SKIP) begin : g_skip
      assign step_skip = skip_en ? CNT_W'(skip_amt) : '0;
    end else begin : g_noskip
      logic unused_skip;
      assign unused_skip = skip_en ^ (^skip_amt);
      assign step_skip   = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mark_q <= MARK_INIT;
    end else if (adv_en) begin
      cnt    <= cnt + step_dist + step_skip;
      mark_q <= new_mark;
    end
  end

endmodule

// File: rtl/nxpc_seq.sv
module nxpc_seq
  import nxpc_pkg::*;
#(
  parameter logic [31:0] BOOT_PC   = 32'h0000_1000,
  parameter int          CNT_W     = 32,
  parameter int          SKIP_MIN  = 3,
  parameter bit          IDLE_SKIP = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [3:0]        br_kind,
  input  logic              idle_loop,
  input  logic [63:0]       op_a,
  input  logic [63:0]       op_b,
  input  logic [15:0]       br_off,
  input  logic [25:0]       jmp_idx,
  input  logic [31:0]       cmp_gap,
  output logic [31:0]       pc,
  output logic              in_slot,
  output logic              slot_nullify,
  output logic              link_we,
  output logic [63:0]       link_data,
  output logic              slot_err,
  output logic [CNT_W-1:0]  cycle_cnt
);

  localparam logic [PC_W-1:0] STEP1 = PC_W'(INSN_B);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INSN_B);

  // architectural state
  logic [PC_W-1:0]   pc_q;
  logic              slot_q;
  logic              taken_q;
  logic [PC_W-1:0]   tgt_q;
  logic              link_q;
  logic              nul_q;
  logic              lwe_q;
  logic [DATA_W-1:0] ldata_q;
  logic              err_q;

  // decode
  logic            is_xfer, is_likely, is_jump, is_link, cond_ok;
  logic [PC_W-1:0] slot_pc, tgt_nx;

  nxpc_cond u_cond (
    .kind_raw  (br_kind),
    .opa       (op_a),
    .opb       (op_b),
    .is_xfer   (is_xfer),
    .is_likely (is_likely),
    .is_jump   (is_jump),
    .is_link   (is_link),
    .taken     (cond_ok)
  );

  nxpc_target u_tgt (
    .cur_pc  (pc_q),
    .is_jump (is_jump),
    .off     (br_off),
    .idx     (jmp_idx),
    .slot_pc (slot_pc),
    .tgt     (tgt_nx)
  );

  // named events
  logic ev_slot_ret;
  logic ev_issue;
  logic ev_skip;
  logic ev_drop;
  logic ev_enter;
  logic skip_ok;

  assign ev_slot_ret = ins_valid & slot_q;
  assign ev_issue    = ins_valid & ~slot_q & is_xfer;

  generate
    if (IDLE_SKIP) begin : g_idle
      assign skip_ok = idle_loop & gap_exceeds(cmp_gap, SKIP_MIN);
    end else begin : g_noidle
      assign skip_ok = 1'b0;
    end
  endgenerate

  assign ev_skip  = ev_issue & cond_ok & skip_ok;
  assign ev_drop  = ev_issue & ~ev_skip & is_likely & ~cond_ok;
  assign ev_enter = ev_issue & ~ev_skip & ~ev_drop;

  // next pc
  logic [PC_W-1:0] pc_nx;

  always_comb begin
    pc_nx = pc_q;
    if (ins_valid) begin
      if (ev_slot_ret)   pc_nx = taken_q ? tgt_q : pc_q + STEP1;
      else if (ev_skip)  pc_nx = pc_q;
      else if (ev_drop)  pc_nx = pc_q + STEP2;
      else               pc_nx = pc_q + STEP1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= BOOT_PC;
      slot_q  <= 1'b0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
      link_q  <= 1'b0;
      nul_q   <= 1'b0;
      lwe_q   <= 1'b0;
      ldata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      nul_q <= ev_drop;
      err_q <= ev_slot_ret & is_xfer;
      lwe_q <= ev_slot_ret & link_q;
      if (ev_slot_ret & link_q) ldata_q <= sext_link(pc_q + STEP1);
      pc_q <= pc_nx;
      if (ev_enter) begin
        slot_q  <= 1'b1;
        taken_q <= cond_ok;
        tgt_q   <= tgt_nx;
        link_q  <= is_link;
      end else if (ev_slot_ret) begin
        slot_q  <= 1'b0;
        link_q  <= 1'b0;
      end
    end
  end

  // cycle counter
  logic            cnt_adv;
  logic [PC_W-1:0] cnt_to;

  assign cnt_adv = ev_slot_ret | ev_skip | ev_drop;
  assign cnt_to  = ev_skip ? pc_q : (ev_drop ? pc_q + STEP2 : slot_pc);

  nxpc_count #(
    .CNT_W     (CNT_W),
    .MARK_INIT (BOOT_PC),
    .IDLE_SKIP (IDLE_SKIP)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (cnt_adv),
    .adv_to   (cnt_to),
    .new_mark (pc_nx),
    .skip_en  (ev_skip),
    .skip_amt (skip_amount(cmp_gap)),
    .cnt      (cycle_cnt)
  );

  assign pc           = pc_q;
  assign in_slot      = slot_q;
  assign slot_nullify = nul_q;
  assign link_we      = lwe_q;
  assign link_data    = ldata_q;
  assign slot_err     = err_q;

endmodule

// File: rtl/nxpc_chk.sv
module nxpc_chk #(
  parameter int CNT_W = 32
)(
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic [31:0]      pc,
  input logic             in_slot,
  input logic             slot_nullify,
  input logic             link_we,
  input logic [63:0]      link_data,
  input logic             slot_err,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic             ev_skip,
  input logic             ev_drop
);

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> ($stable(pc) && $stable(cycle_cnt) && $stable(in_slot)));

  assert_slot_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && ins_valid) |=> !in_slot);

  assert_nullify_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_nullify |-> (pc == $past(pc) + 32'd8 && !link_we && !in_slot));

  assert_drop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> slot_nullify);

  assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_data[31:0] == $past(pc) + 32'd4 &&
                 link_data[63:32] == {32{link_data[31]}} && $past(in_slot)));

  assert_err_after_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |-> $past(in_slot));

  assert_skip_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> ($stable(pc) && !in_slot));

endmodule

bind nxpc_seq nxpc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_valid    (ins_valid),
  .pc           (pc),
  .in_slot      (in_slot),
  .slot_nullify (slot_nullify),
  .link_we      (link_we),
  .link_data    (link_data),
  .slot_err     (slot_err),
  .cycle_cnt    (cycle_cnt),
  .ev_skip      (ev_skip),
  .ev_drop      (ev_drop)
);

// File: tb/sim_nxpc_seq.sv
`timescale 1ns/1ps
module sim_nxpc_seq;

  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [3:0]  br_kind = '0;
  logic        idle_loop = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] cmp_gap = '0;
  logic [31:0] pc;
  logic        in_slot, slot_nullify, link_we, slot_err;
  logic [63:0] link_data;
  logic [31:0] cycle_cnt;

  always #2.5 clk = ~clk;

  nxpc_seq #(.BOOT_PC(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .br_kind(br_kind),
    .idle_loop(idle_loop), .op_a(op_a), .op_b(op_b), .br_off(br_off),
    .jmp_idx(jmp_idx), .cmp_gap(cmp_gap), .pc(pc), .in_slot(in_slot),
    .slot_nullify(slot_nullify), .link_we(link_we), .link_data(link_data),
    .slot_err(slot_err), .cycle_cnt(cycle_cnt)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        slot;
    logic        nul;
    logic        lw;
    logic [63:0] ld;
    logic        err;
    logic [31:0] cnt;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    total = 0;
  int    bad = 0;

  // reference state
  logic [31:0] m_pc = BOOT, m_mark = BOOT, m_cnt = 0, m_tgt = 0;
  logic        m_slot = 0, m_taken = 0, m_link = 0;

  task automatic step(input logic [3:0] k, input logic [63:0] a, input logic [63:0] b,
                      input logic [15:0] im, input logic [25:0] ix, input logic idl,
                      input logic [31:0] gp, input logic v, input string tag);
    exp_t        e;
    logic        c, isb, lk;
    logic [31:0] tg, d;
    @(negedge clk);
    ins_valid = v; br_kind = k; op_a = a; op_b = b; br_off = im;
    jmp_idx = ix; idle_loop = idl; cmp_gap = gp;
    e = '0;
    isb = (k >= 4'd1 && k <= 4'd10);
    lk  = (k >= 4'd5 && k <= 4'd8);
    case (k)
      4'd1, 4'd5: c = (a == b);
      4'd2, 4'd6: c = (a != b);
      4'd3, 4'd7: c = a[63] || (a == 64'd0);
      4'd4, 4'd8: c = !a[63] && (a != 64'd0);
      4'd9, 4'd10: c = 1'b1;
      default: c = 1'b0;
    endcase
    if (k >= 4'd9) tg = {m_pc[31:28] + ((m_pc + 32'd4) >> 28) - m_pc[31:28], ix, 2'b00};
    else tg = m_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
    if (v) begin
      if (m_slot) begin
        e.err = isb;
        e.lw  = m_link;
        d = m_pc + 32'd4;
        e.ld  = {{32{d[31]}}, d};
        m_cnt = m_cnt + ((d - m_mark) >> 1);
        m_pc  = m_taken ? m_tgt : d;
        m_mark = m_pc;
        m_slot = 0; m_link = 0;
      end else if (isb) begin
        if (idl && c && $signed(gp) > 3) begin
          m_cnt = m_cnt + ((m_pc - m_mark) >> 1) + {gp[31:2], 2'b00};
          m_mark = m_pc;
        end else if (lk && !c) begin
          e.nul = 1'b1;
          m_cnt = m_cnt + ((m_pc + 32'd8 - m_mark) >> 1);
          m_pc  = m_pc + 32'd8;
          m_mark = m_pc;
        end else begin
          m_slot = 1; m_taken = c; m_tgt = tg; m_link = (k == 4'd10);
          m_pc = m_pc + 32'd4;
        end
      end else begin
        m_pc = m_pc + 32'd4;
      end
    end
    e.pc = m_pc; e.slot = m_slot; e.cnt = m_cnt;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t  e;
        string t;
        logic  ok;
        e = expq.pop_front();
        t = tagq.pop_front();
        ok = (pc == e.pc) && (in_slot == e.slot) && (slot_nullify == e.nul) &&
             (link_we == e.lw) && (slot_err == e.err) && (cycle_cnt == e.cnt) &&
             (!e.lw || link_data == e.ld);
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s: pc=%h slot=%b nul=%b lw=%b ld=%h err=%b cnt=%h expected pc=%h slot=%b nul=%b lw=%b ld=%h err=%b cnt=%h",
                   t, pc, in_slot, slot_nullify, link_we, link_data, slot_err, cycle_cnt,
                   e.pc, e.slot, e.nul, e.lw, e.ld, e.err, e.cnt);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (pc !== BOOT || cycle_cnt !== 32'd0 || in_slot !== 1'b0 || slot_nullify !== 1'b0 ||
        link_we !== 1'b0 || slot_err !== 1'b0) begin
      bad++;
      $display("FAIL R1: pc=%h cnt=%h slot=%b nul=%b lw=%b err=%b expected pc=%h cnt=0 all low",
               pc, cycle_cnt, in_slot, slot_nullify, link_we, slot_err, BOOT);
    end
    rst_n = 1'b1;

    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R2 sequential");
    step(4'd0, 0, 0, 0, 0, 0, 0, 0, "R2 stall");
    step(4'd12, 0, 0, 0, 0, 0, 0, 1, "R2 unused kind");
    // R3/R4 equal taken, operands change during slot
    step(4'd1, 64'd5, 64'd5, 16'd4, 0, 0, 0, 1, "R3 issue");
    step(4'd0, 64'd1, 64'd9, 0, 0, 0, 0, 1, "R4 taken target R9");
    step(4'd2, 64'd1, 64'd1, 16'd100, 0, 0, 0, 1, "R3 ne issue");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R4 not taken");
    step(4'd3, NEG1, 0, 16'hFFFE, 0, 0, 0, 1, "R5 lez neg");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R4 negative offset");
    step(4'd4, 64'd0, 0, 16'd8, 0, 0, 0, 1, "R5 gtz zero");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R5 gtz zero resolve");
    step(4'd4, 64'h8000_0000_0000_0000, 0, 16'd8, 0, 0, 0, 1, "R5 gtz signed");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R5 gtz signed resolve");
    step(4'd4, 64'd1, 0, 16'd2, 0, 0, 0, 1, "R5 gtz one");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R5 gtz one resolve");
    step(4'd1, 64'h0000_0100_0000_0000, 64'd0, 16'd3, 0, 0, 0, 1, "R5 eq high bit");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R5 eq high bit resolve");
    // R6 likely forms
    step(4'd5, 64'd1, 64'd2, 16'd7, 0, 0, 0, 1, "R6 eq likely drop");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R6 after drop");
    step(4'd6, 64'd1, 64'd2, 16'd1, 0, 0, 0, 1, "R6 ne likely taken");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R6 taken resolve");
    step(4'd7, 64'd5, 0, 16'd1, 0, 0, 0, 1, "R6 lez likely drop");
    step(4'd8, 64'd5, 0, 16'hFFFF, 0, 0, 0, 1, "R6 gtz likely taken");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R6 gtz likely resolve");
    // R7 jump region
    step(4'd9, 0, 0, 0, 26'h0000400, 0, 0, 1, "R7 jump issue");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R7 jump target");
    // R8 jump and link
    step(4'd10, 0, 0, 0, 26'h3F00010, 0, 0, 1, "R8 jal issue");
    step(4'd0, 0, 0, 0, 0, 0, 0, 0, "R8 stall in slot");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R8 link write");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R8 link pulse ends");
    // R11 branch in slot
    step(4'd1, 64'd3, 64'd3, 16'd6, 0, 0, 0, 1, "R11 issue");
    step(4'd2, 64'd1, 64'd2, 16'd40, 0, 0, 0, 1, "R11 branch in slot");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R11 err clears");
    // R10 idle skip
    step(4'd1, 64'd4, 64'd4, 16'hFFFF, 0, 1, 32'd10, 1, "R10 skip gap 10");
    step(4'd1, 64'd4, 64'd4, 16'hFFFF, 0, 1, 32'd3, 1, "R10 gap 3 normal");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R10 gap 3 resolve R9");
    step(4'd1, 64'd4, 64'd4, 16'hFFFF, 0, 1, 32'hFFFF_FFF0, 1, "R10 negative gap");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R10 negative resolve");
    step(4'd2, 64'd4, 64'd4, 16'hFFFF, 0, 1, 32'd50, 1, "R10 cond false");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, "R10 cond false resolve");
    step(4'd10, 0, 0, 0, 26'h3F00010, 1, 32'd7, 1, "R10 jal skip");
    step(4'd0, 0, 0, 0, 0, 1, 32'd99, 1, "R10 idle on plain insn");

    @(negedge clk);
    ins_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule